// File: doc/BRIEF.md
# Array Self-Test Engine

This block wraps a small single-port register array together with a built-in self-test engine that drives it through a dedicated test path. When the test path is selected, the array takes its address, write data and write enable from the engine instead of from the functional port. The engine seeds a maximal-length pattern generator, writes one pattern word into every location, then reads every location back in the same order. The read words are folded into a multiple-input signature register. At the end of the run the signature is compared with an expected value, and the engine reports the result on a sticky pass bit.

A run starts from a start pulse. It can also launch by itself straight after reset, so each power-up checks the array before functional traffic uses it. Accesses are issued on back-to-back cycles, so a run over N words takes a fixed 2N+1 cycles. All control and status pins are plain levels or pulses. The functional port has no handshake and no back-pressure: a write is taken on any cycle in which the functional path owns the array.

Top module: `arr_bist_top`

## Requirements
- R1: The array follows the functional port (`func_we`, `func_addr`, `func_wdata`) when `tst_en` is low and no run is active. A word written there reads back at that address.
- R2: While `tst_en` is high or a run is active, functional writes are ignored, and the contents of the addressed word stay unchanged.
- R3: The pattern source is a right-shifting Galois LFSR whose next state is `(x >> 1) ^ (x[0] ? TAPS : 0)`, with TAPS = 8'hB8 for 8-bit words. It is loaded with `seed` at start, or with 1 when `seed` is zero. During the write pass, address a (ascending from 0) receives the a-th state after loading.
- R4: `busy` rises in the cycle after start is taken and stays high for exactly 2*DEPTH+1 cycles: DEPTH writes, DEPTH reads with no idle cycle between them, and one flush cycle.
- R5: The signature starts at 0 and folds each word read back in address order as `sig = step(sig) ^ word`, where step is the R3 update. Its final value appears on `sig_out`.
- R6: `pass` is 1 after a run exactly when the final signature equals `expect_sig`.
- R7: `done` is a single-cycle pulse, high in the first cycle after `busy` falls.
- R8: `pass` holds its value between runs. It is cleared when a run starts and by reset.
- R9: A start pulse that arrives while a run is active is ignored, and the run length stays unchanged.
- R10: With AUTO_RUN set, a run launches by itself on the first clock edge after reset is released.
- R11: `func_rdata` presents the word at the selected address one clock after the address is applied. Under reset, `busy`, `done` and `pass` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tst_en | input | 1 | Hands the array to the test path |
| func_we | input | 1 | Functional write enable |
| func_addr | input | ADDR_W | Functional address |
| func_wdata | input | DATA_W | Functional write data |
| func_rdata | output | DATA_W | Registered read data |
| bist_start | input | 1 | Start pulse for a run |
| seed | input | DATA_W | Pattern seed (zero selects 1) |
| expect_sig | input | DATA_W | Expected final signature |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Sticky comparison result |
| sig_out | output | DATA_W | Current signature register |

## Verification
The bench sweeps several seeds, including zero and the all-ones and single-high-bit values. For each seed it predicts the full pattern stream and the signature, reads every word back through the functional port, and checks both a correct and a wrong expected signature. A design that misses the zero-seed substitution would lock its generator at zero and store an all-zero array. A design that folds one word too few or too many, or inserts an idle cycle, shows a wrong signature or a run length other than 33 cycles. Start pulses in mid-run and functional writes under test enable are injected, so an engine that restarts, or a mux that still lets functional writes through, is caught by the run length or by a corrupted word on readback.

// File: rtl/arr_bist_pkg.sv
package arr_bist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_FLUSH = 2'd3
  } bist_state_e;

  // Feedback masks for a right-shifting Galois register of maximal length.
  function automatic logic [31:0] galois_taps(input int width);
    case (width)
      4:       galois_taps = 32'h0000_000C;
      5:       galois_taps = 32'h0000_0014;
      6:       galois_taps = 32'h0000_0030;
      7:       galois_taps = 32'h0000_0060;
      8:       galois_taps = 32'h0000_00B8;
      9:       galois_taps = 32'h0000_0110;
      10:      galois_taps = 32'h0000_0240;
      11:      galois_taps = 32'h0000_0500;
      12:      galois_taps = 32'h0000_0E08;
      13:      galois_taps = 32'h0000_1C80;
      14:      galois_taps = 32'h0000_3802;
      15:      galois_taps = 32'h0000_6000;
      16:      galois_taps = 32'h0000_B400;
      default: galois_taps = 32'h0000_00B8;
    endcase
  endfunction

endpackage

// File: rtl/arr_bist_lfsr.sv
// Shared shift-register stage: pattern generator when din is tied to zero,
// signature compactor when din carries read data.
module arr_bist_lfsr #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);

  logic [W-1:0] shifted;

  always_comb begin
    shifted = {1'b0, q[W-1:1]};
    if (q[0]) shifted = shifted ^ TAPS;
    nxt = shifted ^ din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= nxt;
  end

endmodule

// File: rtl/arr_bist_mem.sv
// Single-port array with its port muxed between functional and test paths.
module arr_bist_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_test,
  input  logic              f_we,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [DATA_W-1:0] f_wdata,
  input  logic              t_we,
  input  logic [ADDR_W-1:0] t_addr,
  input  logic [DATA_W-1:0] t_wdata,
  output logic              arr_we,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;

  always_comb begin
    if (sel_test) begin
      arr_we    = t_we;
      arr_addr  = t_addr;
      arr_wdata = t_wdata;
    end else begin
      arr_we    = f_we;
      arr_addr  = f_addr;
      arr_wdata = f_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (arr_we) cells[arr_addr] <= arr_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= cells[arr_addr];
  end

endmodule

// File: rtl/arr_bist_ctrl.sv
// Sequencer: write pass, read pass, flush, then verdict.
module arr_bist_ctrl
  import arr_bist_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter bit AUTO_RUN = 1'b1,
  parameter int DEF_SEED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] seed,
  input  logic [DATA_W-1:0] expect_sig,
  input  logic [DATA_W-1:0] misr_nxt,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              t_we,
  output logic [ADDR_W-1:0] t_addr,
  output logic              pat_load,
  output logic [DATA_W-1:0] pat_seed,
  output logic              pat_step,
  output logic              misr_load,
  output logic              misr_step
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [DATA_W-1:0] SEED_ALT  = DATA_W'(DEF_SEED);

  bist_state_e       state;
  logic [ADDR_W-1:0] addr;
  logic              rd_vld;
  logic              auto_pend;
  logic              go;

  assign go        = (state == ST_IDLE) && (start || auto_pend);
  assign busy      = (state != ST_IDLE);
  assign t_we      = (state == ST_WRITE);
  assign t_addr    = addr;
  assign pat_load  = go;
  assign pat_seed  = (seed == '0) ? SEED_ALT : seed;
  assign pat_step  = (state == ST_WRITE);
  assign misr_load = go;
  assign misr_step = rd_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr      <= '0;
      rd_vld    <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      auto_pend <= AUTO_RUN;
    end else begin
      done   <= 1'b0;
      rd_vld <= (state == ST_READ);
      case (state)
        ST_IDLE: begin
          if (go) begin
            state     <= ST_WRITE;
            addr      <= '0;
            pass      <= 1'b0;
            auto_pend <= 1'b0;
          end
        end
        ST_WRITE: begin
          addr <= addr + 1'b1;
          if (addr == LAST_ADDR) state <= ST_READ;
        end
        ST_READ: begin
          addr <= addr + 1'b1;
          if (addr == LAST_ADDR) state <= ST_FLUSH;
        end
        ST_FLUSH: begin
          state <= ST_IDLE;
          done  <= 1'b1;
          pass  <= (misr_nxt == expect_sig);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/arr_bist_top.sv
module arr_bist_top
  import arr_bist_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter bit AUTO_RUN = 1'b1,
  parameter int DEF_SEED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tst_en,
  input  logic              func_we,
  input  logic [ADDR_W-1:0] func_addr,
  input  logic [DATA_W-1:0] func_wdata,
  output logic [DATA_W-1:0] func_rdata,
  input  logic              bist_start,
  input  logic [DATA_W-1:0] seed,
  input  logic [DATA_W-1:0] expect_sig,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [DATA_W-1:0] sig_out
);

  localparam logic [DATA_W-1:0] TAPS = DATA_W'(galois_taps(DATA_W));

  logic              t_we;
  logic [ADDR_W-1:0] t_addr;
  logic              pat_load, pat_step, misr_load, misr_step;
  logic [DATA_W-1:0] pat_seed, pat_q, pat_nxt;
  logic [DATA_W-1:0] misr_q, misr_nxt;
  logic              arr_we;
  logic              sel_test;

  assign sel_test = tst_en | busy;
  assign sig_out  = misr_q;

  arr_bist_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AUTO_RUN(AUTO_RUN), .DEF_SEED(DEF_SEED)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(bist_start), .seed(seed),
    .expect_sig(expect_sig), .misr_nxt(misr_nxt),
    .busy(busy), .done(done), .pass(pass),
    .t_we(t_we), .t_addr(t_addr),
    .pat_load(pat_load), .pat_seed(pat_seed), .pat_step(pat_step),
    .misr_load(misr_load), .misr_step(misr_step)
  );

  arr_bist_lfsr #(.W(DATA_W), .TAPS(TAPS)) u_pat (
    .clk(clk), .rst_n(rst_n), .load(pat_load), .load_val(pat_seed),
    .step(pat_step), .din('0), .q(pat_q), .nxt(pat_nxt)
  );

  arr_bist_lfsr #(.W(DATA_W), .TAPS(TAPS)) u_misr (
    .clk(clk), .rst_n(rst_n), .load(misr_load), .load_val('0),
    .step(misr_step), .din(func_rdata), .q(misr_q), .nxt(misr_nxt)
  );

  arr_bist_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .sel_test(sel_test),
    .f_we(func_we), .f_addr(func_addr), .f_wdata(func_wdata),
    .t_we(t_we), .t_addr(t_addr), .t_wdata(pat_q),
    .arr_we(arr_we), .rdata(func_rdata)
  );

endmodule

// File: rtl/arr_bist_chk.sv
module arr_bist_chk (
  input logic clk,
  input logic rst_n,
  input logic tst_en,
  input logic func_we,
  input logic bist_start,
  input logic busy,
  input logic done,
  input logic pass,
  input logic arr_we
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R7

  AST_PASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(pass)); // R8

  AST_PASS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !pass); // R8

  AST_FUNC_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (tst_en && !busy && func_we) |-> !arr_we); // R2

  AST_START_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bist_start && !done) |=> (busy || done)); // R9

endmodule

bind arr_bist_top arr_bist_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tst_en(tst_en), .func_we(func_we),
  .bist_start(bist_start), .busy(busy), .done(done), .pass(pass),
  .arr_we(arr_we)
);

// File: tb/test_arr_bist_top.sv
module test_arr_bist_top;

  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int RUNLEN = 2 * DEPTH + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tst_en = 1'b0;
  logic          func_we = 1'b0;
  logic [AW-1:0] func_addr = '0;
  logic [DW-1:0] func_wdata = '0;
  logic [DW-1:0] func_rdata;
  logic          bist_start = 1'b0;
  logic [DW-1:0] seed = '0;
  logic [DW-1:0] expect_sig = '0;
  logic          busy, done, pass;
  logic [DW-1:0] sig_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] pat [DEPTH];

  always #10 clk = ~clk;  // 50 MHz

  arr_bist_top #(.ADDR_W(AW), .DATA_W(DW), .AUTO_RUN(1'b1), .DEF_SEED(1)) i_arr_bist_top (
    .clk(clk), .rst_n(rst_n), .tst_en(tst_en), .func_we(func_we),
    .func_addr(func_addr), .func_wdata(func_wdata), .func_rdata(func_rdata),
    .bist_start(bist_start), .seed(seed), .expect_sig(expect_sig),
    .busy(busy), .done(done), .pass(pass), .sig_out(sig_out)
  );

  function automatic logic [DW-1:0] stepf(input logic [DW-1:0] x);
    logic [DW-1:0] y;
    y = {1'b0, x[DW-1:1]};
    if (x[0]) y = y ^ 8'hB8;
    return y;
  endfunction

  // Fills pat[] with the expected array image and returns the signature.
  function automatic logic [DW-1:0] model(input logic [DW-1:0] s);
    logic [DW-1:0] p, m;
    p = (s == '0) ? 8'h01 : s;
    m = '0;
    for (int a = 0; a < DEPTH; a++) begin
      pat[a] = p;
      m = stepf(m) ^ p;
      p = stepf(p);
    end
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Waits out an active run, counting busy cycles already begun.
  task automatic wait_run(output int cnt, input bit poke);
    cnt = 0;
    while (busy) begin
      cnt++;
      bist_start = (poke && cnt == 5);
      @(negedge clk);
    end
    bist_start = 1'b0;
  endtask

  task automatic readback(input string tag);
    tst_en = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      func_addr = AW'(a);
      @(negedge clk);
      chk({tag, " R3 R11 readback"}, func_rdata, pat[a]);
    end
  endtask

  task automatic run(input logic [DW-1:0] s, input bit good, input bit poke);
    logic [DW-1:0] sig;
    int cnt;
    sig = model(s);
    seed = s;
    expect_sig = good ? sig : ~sig;
    bist_start = 1'b1;
    @(negedge clk);
    bist_start = 1'b0;
    chk("R4 busy after start", busy, 1);
    wait_run(cnt, poke);
    chk(poke ? "R9 run length with mid-run start" : "R4 run length", cnt, RUNLEN);
    chk("R7 done at busy fall", done, 1);
    chk("R5 signature", sig_out, sig);
    chk("R6 pass verdict", pass, good);
    repeat (4) @(negedge clk);
    chk("R7 done single cycle", done, 0);
    chk("R8 pass held", pass, good);
    readback("seed sweep");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int cnt;
    logic [DW-1:0] sig;
    // Reset state and power-up run
    seed = 8'h5A;
    sig = model(8'h5A);
    expect_sig = sig;
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", busy, 0);
    chk("R11 done in reset", done, 0);
    chk("R11 pass in reset", pass, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 auto launch", busy, 1);
    wait_run(cnt, 1'b0);
    chk("R10 R4 auto run length", cnt, RUNLEN);
    chk("R10 R6 auto pass", pass, 1);
    chk("R10 R5 auto signature", sig_out, sig);
    readback("auto");

    // Seed sweep, correct and wrong expectations
    run(8'h00, 1'b1, 1'b0);
    run(8'hFF, 1'b1, 1'b0);
    run(8'h80, 1'b0, 1'b0);
    run(8'h3C, 1'b0, 1'b0);
    run(8'hC3, 1'b1, 1'b1);

    // R1: functional write with test path released
    tst_en = 1'b0;
    func_addr = 4'd3; func_wdata = 8'hA5; func_we = 1'b1;
    @(negedge clk);
    func_we = 1'b0;
    @(negedge clk);
    chk("R1 functional write", func_rdata, 8'hA5);
    func_addr = 4'd9; func_wdata = 8'h17; func_we = 1'b1;
    @(negedge clk);
    func_we = 1'b0;
    func_addr = 4'd3;
    @(negedge clk);
    chk("R1 neighbour intact", func_rdata, 8'hA5);

    // R2: functional writes while test enable is high
    tst_en = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      func_addr = AW'(a); func_wdata = 8'h00; func_we = 1'b1;
      @(negedge clk);
    end
    func_we = 1'b0;
    tst_en = 1'b0;
    func_addr = 4'd3;
    @(negedge clk);
    chk("R2 write ignored addr 3", func_rdata, 8'hA5);
    func_addr = 4'd9;
    @(negedge clk);
    chk("R2 write ignored addr 9", func_rdata, 8'h17);

    // R2: functional writes during an active run do not disturb the run
    sig = model(8'h21);
    seed = 8'h21; expect_sig = sig;
    bist_start = 1'b1;
    @(negedge clk);
    bist_start = 1'b0;
    func_we = 1'b1; func_wdata = 8'hEE; func_addr = 4'd7;
    wait_run(cnt, 1'b0);
    func_we = 1'b0;
    chk("R2 run unaffected by functional writes", pass, 1);
    chk("R2 signature under traffic", sig_out, sig);
    readback("traffic");

    summary();
    $finish;
  end

endmodule